// File: doc/BRIEF.md
# Timer Register Front End

This block is the software-visible face of a simple up-counting time base. It sits on a small synchronous bus with a byte address, write data, a write strobe and registered read data. It keeps the control words, the prescale and reload values, the interrupt and DMA enables and the pending-update flag. It drives these values as plain control lines into a separate counter engine.

The counter engine reports back four things: its current count, each update it performs, the subset of updates that should raise the flag, and its internal run state. It can also ask for the enable bit to be dropped when a one-shot run finishes. From these inputs the block produces a level interrupt, a single-cycle DMA request and a selectable synchronisation trigger. A read of the count can carry a copy of the pending flag in its top bit, so the count and the roll-over are seen together.

Top module: `timer_regs`

## Requirements
- R1: After reset every register reads 0, except the reload value at 0x2C, which reads 0x0000FFFF. All control outputs are 0.
- R2: Control word 0x00 keeps run-enable at bit 0, update-inhibit at bit 1, request-source at bit 2, one-shot at bit 3, reload-buffering at bit 7 and flag-mirror at bit 11. All other bits read 0, so writing all ones reads back 0x0000088F. Bits 0 to 3 and bit 7 drive the matching control outputs.
- R3: A pulse on `tb_opm_stop` clears run-enable on the next edge. This takes priority over a software write in the same cycle.
- R4: Status bit 0 at 0x10 is set on the edge after `tb_update_flagged`. A write of 0 clears it and a write of 1 leaves it unchanged. If a set and a clear fall in the same cycle, the set wins.
- R5: Writing 1 to bit 0 at 0x14 gives `ctl_ug` high for exactly the one cycle after the write edge. Writing 0 gives no pulse, and the register always reads 0.
- R6: A read of 0x24 returns `tb_count` in the low bits and 0 in bits 30:16. Bit 31 equals the status flag when flag-mirror is set, and 0 otherwise.
- R7: A write to 0x24 gives `ctl_cnt_load` high for one cycle, with `ctl_cnt_val` equal to the low 16 bits of the written data.
- R8: `irq` is high exactly while the status flag and interrupt-enable (bit 0 at 0x0C) are both 1.
- R9: `dma_req` is a one-cycle pulse on the edge after a flagged update, and only while DMA-enable (bit 8 at 0x0C) is 1. Register 0x0C reads back only bits 8 and 0.
- R10: The trigger field at bits 6:4 of 0x04 selects `trig_out`: 000 gives `ctl_ug`, 001 gives `tb_run`, 010 gives `tb_update`, and 011 to 111 give 0. The register reads back only bits 6:4.
- R11: The prescale value at 0x28 and the reload value at 0x2C store the low 16 bits of the write data, read back with upper bits 0, and drive `ctl_psc` and `ctl_arr`.
- R12: Writes to the reserved offsets 0x08, 0x18, 0x1C and 0x20 change nothing, and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 32 | Read data, registered one cycle after the address |
| tb_count | input | CNT_W | Current count from the counter engine |
| tb_update | input | 1 | Update event performed by the engine |
| tb_update_flagged | input | 1 | Update that should set the status flag |
| tb_run | input | 1 | Engine's internal counting-enable state |
| tb_opm_stop | input | 1 | One-shot end: request to clear run-enable |
| ctl_cen | output | 1 | Run-enable |
| ctl_udis | output | 1 | Update inhibit |
| ctl_urs | output | 1 | Update request source select |
| ctl_opm | output | 1 | One-shot mode |
| ctl_arpe | output | 1 | Reload buffering enable |
| ctl_psc | output | CNT_W | Prescale value |
| ctl_arr | output | CNT_W | Reload value |
| ctl_ug | output | 1 | Software update-generate pulse |
| ctl_cnt_load | output | 1 | Count load strobe |
| ctl_cnt_val | output | CNT_W | Value to load into the count |
| irq | output | 1 | Interrupt request (level) |
| dma_req | output | 1 | DMA request (pulse) |
| trig_out | output | 1 | Selected synchronisation trigger |

## Verification
Some rules are checked on every cycle. These are: the flag setting one edge after a flagged update, a write of 1 leaving a set flag in place, the update-generate pulse always tracing back to a write of 1, DMA pulses only following a flagged update while enabled, the interrupt never rising without its enable, unused trigger codes holding the output low, read bit 31 staying low while mirroring is off, and a one-shot stop dropping run-enable. The bench scenarios show the rest. These are the exact read-back masks of each register, the reset value of the reload register, the collision of set and clear, and the ignored reserved offsets. They also cover the count readback with and without the mirrored flag, and each trigger source seen at the pin.

// File: rtl/tmr_regs_pkg.sv
package tmr_regs_pkg;

    localparam int DATA_W = 32;

    // Byte offsets (behavioural: software decodes them)
    localparam logic [5:0] OFF_CTL1 = 6'h00;
    localparam logic [5:0] OFF_CTL2 = 6'h04;
    localparam logic [5:0] OFF_IEN  = 6'h0C;
    localparam logic [5:0] OFF_STAT = 6'h10;
    localparam logic [5:0] OFF_EVG  = 6'h14;
    localparam logic [5:0] OFF_CNT  = 6'h24;
    localparam logic [5:0] OFF_PSC  = 6'h28;
    localparam logic [5:0] OFF_ARR  = 6'h2C;

    // Bit positions
    localparam int B_CEN    = 0;
    localparam int B_UDIS   = 1;
    localparam int B_URS    = 2;
    localparam int B_OPM    = 3;
    localparam int B_ARPE   = 7;
    localparam int B_MIRROR = 11;
    localparam int B_TSEL   = 4;
    localparam int TSEL_W   = 3;
    localparam int B_IRQEN  = 0;
    localparam int B_DMAEN  = 8;
    localparam int B_FLAG   = 0;
    localparam int B_UG     = 0;
    localparam int B_CPY    = 31;

    typedef enum logic [TSEL_W-1:0] {
        TRG_SW_UPD = 3'b000,
        TRG_RUN    = 3'b001,
        TRG_UPDATE = 3'b010
    } trg_src_e;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_CTL1, SEL_CTL2, SEL_IEN, SEL_STAT,
        SEL_EVG, SEL_CNT, SEL_PSC, SEL_ARR
    } reg_sel_e;

    typedef struct packed {
        logic mirror;
        logic arpe;
        logic opm;
        logic urs;
        logic udis;
        logic cen;
    } ctl1_t;

    function automatic ctl1_t ctl1_from_word(logic [DATA_W-1:0] w);
        ctl1_t c;
        c.mirror = w[B_MIRROR];
        c.arpe   = w[B_ARPE];
        c.opm    = w[B_OPM];
        c.urs    = w[B_URS];
        c.udis   = w[B_UDIS];
        c.cen    = w[B_CEN];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctl1_to_word(ctl1_t c);
        logic [DATA_W-1:0] w;
        w           = '0;
        w[B_MIRROR] = c.mirror;
        w[B_ARPE]   = c.arpe;
        w[B_OPM]    = c.opm;
        w[B_URS]    = c.urs;
        w[B_UDIS]   = c.udis;
        w[B_CEN]    = c.cen;
        return w;
    endfunction

endpackage

// File: rtl/treg_decode.sv
module treg_decode
    import tmr_regs_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    always_comb begin
        if      (addr == ADDR_W'(OFF_CTL1)) sel = SEL_CTL1;
        else if (addr == ADDR_W'(OFF_CTL2)) sel = SEL_CTL2;
        else if (addr == ADDR_W'(OFF_IEN))  sel = SEL_IEN;
        else if (addr == ADDR_W'(OFF_STAT)) sel = SEL_STAT;
        else if (addr == ADDR_W'(OFF_EVG))  sel = SEL_EVG;
        else if (addr == ADDR_W'(OFF_CNT))  sel = SEL_CNT;
        else if (addr == ADDR_W'(OFF_PSC))  sel = SEL_PSC;
        else if (addr == ADDR_W'(OFF_ARR))  sel = SEL_ARR;
        else                                sel = SEL_NONE;
    end
endmodule

// File: rtl/treg_field.sv
module treg_field #(
    parameter int          W       = 16,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= RST_VAL;
        else if (wr) q <= din;
    end
endmodule

// File: rtl/treg_flag.sv
module treg_flag (
    input  logic clk,
    input  logic rst,
    input  logic hw_set,
    input  logic sw_wr,
    input  logic sw_bit,
    input  logic irq_en,
    input  logic dma_en,
    output logic flag,
    output logic irq,
    output logic dma_req
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag    <= 1'b0;
            dma_req <= 1'b0;
        end else begin
            if (hw_set)                flag <= 1'b1;
            else if (sw_wr && !sw_bit) flag <= 1'b0;
            dma_req <= hw_set && dma_en;
        end
    end

    assign irq = flag && irq_en;
endmodule

// File: rtl/treg_trig.sv
module treg_trig
    import tmr_regs_pkg::*;
(
    input  logic [TSEL_W-1:0] sel,
    input  logic              sw_upd,
    input  logic              run,
    input  logic              upd,
    output logic              trig
);
    always_comb begin
        case (sel)
            TRG_SW_UPD: trig = sw_upd;
            TRG_RUN:    trig = run;
            TRG_UPDATE: trig = upd;
            default:    trig = 1'b0;
        endcase
    end
endmodule

// File: rtl/timer_regs.sv
module timer_regs
    import tmr_regs_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_we,
    output logic [31:0]       bus_rdata,
    input  logic [CNT_W-1:0]  tb_count,
    input  logic              tb_update,
    input  logic              tb_update_flagged,
    input  logic              tb_run,
    input  logic              tb_opm_stop,
    output logic              ctl_cen,
    output logic              ctl_udis,
    output logic              ctl_urs,
    output logic              ctl_opm,
    output logic              ctl_arpe,
    output logic [CNT_W-1:0]  ctl_psc,
    output logic [CNT_W-1:0]  ctl_arr,
    output logic              ctl_ug,
    output logic              ctl_cnt_load,
    output logic [CNT_W-1:0]  ctl_cnt_val,
    output logic              irq,
    output logic              dma_req,
    output logic              trig_out
);
    localparam logic [CNT_W-1:0] ARR_RST = '1;

    reg_sel_e          sel;
    reg_sel_e          wsel;
    ctl1_t             ctl1_q;
    logic [TSEL_W-1:0] tsel_q;
    logic              ien_irq;
    logic              ien_dma;
    logic              flag;
    logic              mirror_on;
    logic [31:0]       rd_next;

    treg_decode #(.ADDR_W(ADDR_W)) u_dec (.addr(bus_addr), .sel(sel));

    assign wsel = bus_we ? sel : SEL_NONE;

    // Control word 1, with hardware clear of run-enable on one-shot end
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl1_q <= '0;
        end else begin
            if (wsel == SEL_CTL1) ctl1_q <= ctl1_from_word(bus_wdata);
            if (tb_opm_stop)      ctl1_q.cen <= 1'b0;
        end
    end

    // Trigger select and request enables
    always_ff @(posedge clk) begin
        if (rst) begin
            tsel_q  <= '0;
            ien_irq <= 1'b0;
            ien_dma <= 1'b0;
        end else begin
            if (wsel == SEL_CTL2) tsel_q <= bus_wdata[B_TSEL +: TSEL_W];
            if (wsel == SEL_IEN) begin
                ien_irq <= bus_wdata[B_IRQEN];
                ien_dma <= bus_wdata[B_DMAEN];
            end
        end
    end

    // Self-clearing strobes: update-generate and count load
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_ug       <= 1'b0;
            ctl_cnt_load <= 1'b0;
            ctl_cnt_val  <= '0;
        end else begin
            ctl_ug       <= (wsel == SEL_EVG) && bus_wdata[B_UG];
            ctl_cnt_load <= (wsel == SEL_CNT);
            if (wsel == SEL_CNT) ctl_cnt_val <= bus_wdata[CNT_W-1:0];
        end
    end

    treg_field #(.W(CNT_W), .RST_VAL('0)) u_psc (
        .clk(clk), .rst(rst), .wr(wsel == SEL_PSC),
        .din(bus_wdata[CNT_W-1:0]), .q(ctl_psc)
    );

    treg_field #(.W(CNT_W), .RST_VAL(ARR_RST)) u_arr (
        .clk(clk), .rst(rst), .wr(wsel == SEL_ARR),
        .din(bus_wdata[CNT_W-1:0]), .q(ctl_arr)
    );

    treg_flag u_flag (
        .clk(clk), .rst(rst),
        .hw_set(tb_update_flagged),
        .sw_wr(wsel == SEL_STAT),
        .sw_bit(bus_wdata[B_FLAG]),
        .irq_en(ien_irq), .dma_en(ien_dma),
        .flag(flag), .irq(irq), .dma_req(dma_req)
    );

    treg_trig u_trig (
        .sel(tsel_q), .sw_upd(ctl_ug), .run(tb_run), .upd(tb_update),
        .trig(trig_out)
    );

    assign mirror_on = ctl1_q.mirror;
    assign ctl_cen   = ctl1_q.cen;
    assign ctl_udis  = ctl1_q.udis;
    assign ctl_urs   = ctl1_q.urs;
    assign ctl_opm   = ctl1_q.opm;
    assign ctl_arpe  = ctl1_q.arpe;

    // Read mux
    always_comb begin
        rd_next = '0;
        case (sel)
            SEL_CTL1: rd_next = ctl1_to_word(ctl1_q);
            SEL_CTL2: rd_next[B_TSEL +: TSEL_W] = tsel_q;
            SEL_IEN: begin
                rd_next[B_IRQEN] = ien_irq;
                rd_next[B_DMAEN] = ien_dma;
            end
            SEL_STAT: rd_next[B_FLAG] = flag;
            SEL_CNT: begin
                rd_next[CNT_W-1:0] = tb_count;
                rd_next[B_CPY]     = mirror_on && flag;
            end
            SEL_PSC: rd_next[CNT_W-1:0] = ctl_psc;
            SEL_ARR: rd_next[CNT_W-1:0] = ctl_arr;
            default: rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) bus_rdata <= '0;
        else     bus_rdata <= rd_next;
    end

endmodule

// File: rtl/timer_regs_chk.sv
module timer_regs_chk
    import tmr_regs_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              bus_we,
    input logic [31:0]       bus_rdata,
    input logic              tb_update_flagged,
    input logic              tb_opm_stop,
    input logic              ctl_cen,
    input logic              ctl_ug,
    input logic              irq,
    input logic              dma_req,
    input logic              trig_out,
    input logic              flag,
    input logic              mirror_on,
    input logic              ien_irq,
    input logic              ien_dma,
    input logic [TSEL_W-1:0] tsel_q
);
    logic stat_wr_one;
    logic evg_wr_one;
    assign stat_wr_one = bus_we && (bus_addr == ADDR_W'(OFF_STAT)) && bus_wdata[B_FLAG];
    assign evg_wr_one  = bus_we && (bus_addr == ADDR_W'(OFF_EVG)) && bus_wdata[B_UG];

    p_stop_clears_r3: assert property (@(posedge clk) disable iff (rst)
        tb_opm_stop |=> !ctl_cen);

    p_flag_set_r4: assert property (@(posedge clk) disable iff (rst)
        tb_update_flagged |=> flag);

    p_flag_write_one_r4: assert property (@(posedge clk) disable iff (rst)
        (flag && stat_wr_one) |=> flag);

    p_ug_source_r5: assert property (@(posedge clk) disable iff (rst)
        ctl_ug |-> $past(evg_wr_one));

    p_mirror_off_r6: assert property (@(posedge clk) disable iff (rst)
        !mirror_on |=> !bus_rdata[B_CPY]);

    p_irq_needs_en_r8: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ien_irq && flag));

    p_dma_cause_r9: assert property (@(posedge clk) disable iff (rst)
        dma_req |-> ($past(tb_update_flagged) && $past(ien_dma)));

    p_trig_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (tsel_q > 3'b010) |-> !trig_out);

endmodule

bind timer_regs timer_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata),
    .tb_update_flagged(tb_update_flagged), .tb_opm_stop(tb_opm_stop),
    .ctl_cen(ctl_cen), .ctl_ug(ctl_ug), .irq(irq), .dma_req(dma_req),
    .trig_out(trig_out), .flag(flag), .mirror_on(mirror_on),
    .ien_irq(ien_irq), .ien_dma(ien_dma), .tsel_q(tsel_q)
);

// File: tb/timer_regs_bench.sv
`timescale 1ns/1ps
module timer_regs_bench;
    localparam int ADDR_W = 6;
    localparam int CNT_W  = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic              bus_we = 1'b0;
    logic [31:0]       bus_rdata;
    logic [CNT_W-1:0]  tb_count = '0;
    logic              tb_update = 1'b0;
    logic              tb_update_flagged = 1'b0;
    logic              tb_run = 1'b0;
    logic              tb_opm_stop = 1'b0;
    logic ctl_cen, ctl_udis, ctl_urs, ctl_opm, ctl_arpe;
    logic [CNT_W-1:0] ctl_psc, ctl_arr, ctl_cnt_val;
    logic ctl_ug, ctl_cnt_load, irq, dma_req, trig_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_req = 1'b0;
    logic        rd_seen = 1'b0;

    always #2.5 clk = ~clk;

    timer_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_timer_regs (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .tb_count(tb_count),
        .tb_update(tb_update), .tb_update_flagged(tb_update_flagged),
        .tb_run(tb_run), .tb_opm_stop(tb_opm_stop),
        .ctl_cen(ctl_cen), .ctl_udis(ctl_udis), .ctl_urs(ctl_urs),
        .ctl_opm(ctl_opm), .ctl_arpe(ctl_arpe), .ctl_psc(ctl_psc),
        .ctl_arr(ctl_arr), .ctl_ug(ctl_ug), .ctl_cnt_load(ctl_cnt_load),
        .ctl_cnt_val(ctl_cnt_val), .irq(irq), .dma_req(dma_req),
        .trig_out(trig_out)
    );

    task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    // Monitor: compare registered read data against queued expectations
    always @(posedge clk) rd_seen <= rd_req;
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
        end
    end

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [5:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        bus_addr = a; rd_req = 1'b1;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    task automatic flag_pulse();
        @(negedge clk);
        tb_update_flagged = 1'b1;
        @(negedge clk);
        tb_update_flagged = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check({31'b0, ctl_cen}, 0, "R1 cen");
        check({16'b0, ctl_arr}, 32'h0000FFFF, "R1 arr out");
        check({31'b0, irq | dma_req | ctl_ug | ctl_cnt_load}, 0, "R1 strobes");
        rd(6'h00, 0, "R1 ctl1");
        rd(6'h04, 0, "R1 ctl2");
        rd(6'h0C, 0, "R1 ien");
        rd(6'h10, 0, "R1 stat");
        rd(6'h28, 0, "R1 psc");
        rd(6'h2C, 32'h0000FFFF, "R1 arr");
        rd(6'h24, 0, "R1 cnt");

        // R2 control word masks and outputs
        wr(6'h00, 32'hFFFFFFFF);
        rd(6'h00, 32'h0000088F, "R2 ctl1 mask");
        check({27'b0, ctl_arpe, ctl_opm, ctl_urs, ctl_udis, ctl_cen}, 32'h1F, "R2 outputs");
        wr(6'h00, 32'h00000006);
        check({27'b0, ctl_arpe, ctl_opm, ctl_urs, ctl_udis, ctl_cen}, 32'h06, "R2 partial");
        wr(6'h00, 32'hFFFFFFFF);

        // R11 prescale and reload
        wr(6'h28, 32'hABCD1234);
        wr(6'h2C, 32'h555500C3);
        rd(6'h28, 32'h00001234, "R11 psc");
        rd(6'h2C, 32'h000000C3, "R11 arr");
        check({16'b0, ctl_psc}, 32'h1234, "R11 psc out");
        check({16'b0, ctl_arr}, 32'h00C3, "R11 arr out");

        // R10 / R9 read masks
        wr(6'h04, 32'hFFFFFFFF);
        rd(6'h04, 32'h00000070, "R10 ctl2 mask");
        wr(6'h0C, 32'hFFFFFFFF);
        rd(6'h0C, 32'h00000101, "R9 ien mask");

        // R12 reserved offsets
        wr(6'h08, 32'hFFFFFFFF);
        wr(6'h18, 32'hFFFFFFFF);
        wr(6'h1C, 32'hFFFFFFFF);
        wr(6'h20, 32'hFFFFFFFF);
        rd(6'h08, 0, "R12 rsv 08");
        rd(6'h1C, 0, "R12 rsv 1C");
        rd(6'h00, 32'h0000088F, "R12 ctl1 kept");
        check({16'b0, ctl_psc}, 32'h1234, "R12 psc kept");
        check({16'b0, ctl_arr}, 32'h00C3, "R12 arr kept");
        check({31'b0, irq | ctl_ug | ctl_cnt_load}, 0, "R12 no strobe");

        // R3 one-shot stop
        @(negedge clk); tb_opm_stop = 1'b1;
        @(negedge clk); tb_opm_stop = 1'b0;
        check({31'b0, ctl_cen}, 0, "R3 cen cleared");
        rd(6'h00, 32'h0000088E, "R3 ctl1 readback");
        @(negedge clk);
        bus_addr = 6'h00; bus_wdata = 32'h1; bus_we = 1'b1; tb_opm_stop = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; tb_opm_stop = 1'b0;
        check({31'b0, ctl_cen}, 0, "R3 stop beats write");
        wr(6'h00, 32'h00000800);

        // R4 / R6 / R8 / R9 flag behaviour (mirror on, both enables on)
        tb_count = 16'h0042;
        flag_pulse();
        check({31'b0, dma_req}, 1, "R9 dma pulse");
        check({31'b0, irq}, 1, "R8 irq on");
        @(negedge clk);
        check({31'b0, dma_req}, 0, "R9 dma one cycle");
        rd(6'h10, 1, "R4 flag set");
        rd(6'h24, 32'h80000042, "R6 mirrored");
        wr(6'h10, 32'h00000001);
        rd(6'h10, 1, "R4 write one ignored");
        check({31'b0, irq}, 1, "R8 irq held");
        wr(6'h10, 32'h00000000);
        rd(6'h10, 0, "R4 write zero clears");
        check({31'b0, irq}, 0, "R8 irq off");
        rd(6'h24, 32'h00000042, "R6 flag clear");
        @(negedge clk);
        bus_addr = 6'h10; bus_wdata = 32'h0; bus_we = 1'b1; tb_update_flagged = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; tb_update_flagged = 1'b0;
        rd(6'h10, 1, "R4 set beats clear");

        // R6 mirror off, R8 / R9 enables
        wr(6'h00, 32'h00000000);
        tb_count = 16'hBEEF;
        rd(6'h24, 32'h0000BEEF, "R6 no mirror");
        wr(6'h0C, 32'h00000000);
        check({31'b0, irq}, 0, "R8 irq disabled");
        wr(6'h10, 0);
        wr(6'h0C, 32'h00000001);
        flag_pulse();
        check({31'b0, dma_req}, 0, "R9 dma disabled");
        check({31'b0, irq}, 1, "R8 irq enabled");
        wr(6'h10, 0);

        // R5 update-generate with R10 mode 000
        wr(6'h04, 32'h00000000);
        wr(6'h14, 32'h00000001);
        check({31'b0, ctl_ug}, 1, "R5 ug pulse");
        check({31'b0, trig_out}, 1, "R10 mode 000");
        @(negedge clk);
        check({31'b0, ctl_ug}, 0, "R5 ug self clear");
        wr(6'h14, 32'h00000000);
        check({31'b0, ctl_ug}, 0, "R5 write zero");
        rd(6'h14, 0, "R5 reads zero");

        // R10 other modes
        wr(6'h04, 32'h00000010);
        @(negedge clk); tb_run = 1'b1; #1;
        check({31'b0, trig_out}, 1, "R10 mode 001");
        tb_run = 1'b0; #1;
        check({31'b0, trig_out}, 0, "R10 mode 001 low");
        wr(6'h04, 32'h00000020);
        @(negedge clk); tb_update = 1'b1; #1;
        check({31'b0, trig_out}, 1, "R10 mode 010");
        tb_update = 1'b0;
        wr(6'h04, 32'h00000030);
        @(negedge clk); tb_update = 1'b1; tb_run = 1'b1; #1;
        check({31'b0, trig_out}, 0, "R10 mode 011");
        wr(6'h04, 32'h00000070);
        #1;
        check({31'b0, trig_out}, 0, "R10 mode 111");
        tb_update = 1'b0; tb_run = 1'b0;

        // R7 count load
        wr(6'h24, 32'h12340099);
        check({31'b0, ctl_cnt_load}, 1, "R7 load strobe");
        check({16'b0, ctl_cnt_val}, 32'h0099, "R7 load value");
        @(negedge clk);
        check({31'b0, ctl_cnt_load}, 0, "R7 strobe one cycle");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule